// File: doc/BRIEF.md
# Gated Asynchronous Serial Transmitter

This block sends characters out of a single serial line. Software or a host engine writes bytes into a 16-entry queue. A small state machine takes them from the queue and sends each one as a character frame. The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. One bit is sent per shift enable. The shift enable comes from one of two sources. The first is a one-cycle 1X pulse from a rate generator elsewhere on the chip. The second is a falling edge of an external transmit clock, brought in through a synchronizer.

The active-low clear-to-send input can hold back new characters. A character that has already started always runs to its stop bit. Any change of clear-to-send, in either direction, sets a sticky change flag that can raise an interrupt. The line output is forced to mark (high) when the transmitter is disabled. It is also held at mark in local loopback, where the bit stream appears on a separate internal loop output instead.

The state machine has four states:
- `TX_IDLE`: the line is at mark.
- `TX_START`: the start bit is on the line.
- `TX_DATA`: the eight data bits are sent.
- `TX_STOP`: the stop bit is on the line.

Its transitions, each taken on a shift enable, are:
- IDLE to START: the queue has data and the gate is open. The head byte is popped.
- START to DATA: always.
- DATA to DATA: until the eighth bit has been sent.
- DATA to STOP: after the eighth bit.
- STOP to START: back to back, when another character is ready. The next byte is popped.
- STOP to IDLE: otherwise.

Disabling the transmitter forces IDLE at once, without waiting for a shift enable.

Top module: `ser_tx_gated`

## Requirements
- R1: After reset, `txd` is 1, `loop_data` is 1, `fifo_not_full` is 1, and `overrun`, `cts_chg` and `irq` are 0.
- R2: Each character goes out as one start bit at 0, then data bits 0 through 7 in that order, then one stop bit at 1. Each bit lasts exactly one shift-enable period.
- R3: The queue holds 16 bytes. `fifo_not_full` is 0 exactly while 16 bytes are held.
- R4: A write while the queue is full is discarded, and `overrun` is 1 for the single cycle after that write.
- R5: While `tx_enable` is 0, `txd` is 1, no character starts, and queued bytes are kept.
- R6: While `loopback` is 1, `txd` is 1 and the frame bit stream appears on `loop_data`. While `loopback` is 0, `loop_data` is 1.
- R7: With `cts_gate_en` at 1, no new character starts while the synchronized `cts_n` is 1.
- R8: A character that has started completes in full even if `cts_n` goes to 1 during it.
- R9: Every change of `cts_n`, low-to-high or high-to-low, sets `cts_chg` within 3 clock cycles. `cts_chg` stays set until a `cts_chg_clr` pulse.
- R10: `irq` is 1 exactly when `cts_chg` is 1 and `cts_irq_en` is 1.
- R11: With `ext_clk_sel` at 1, `bit_tick` is ignored. Bits advance on falling edges of `ext_txclk`, and `txd` changes only while `ext_txclk` is low.
- R12: Characters leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| tx_enable | input | 1 | Transmitter enable |
| loopback | input | 1 | Local loopback: line held at mark, stream on loop_data |
| ext_clk_sel | input | 1 | 1 selects the external transmit clock as the shift source |
| bit_tick | input | 1 | Internal 1X shift enable, one cycle wide |
| ext_txclk | input | 1 | External transmit clock, asynchronous |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cts_gate_en | input | 1 | 1 makes clear-to-send gate new characters |
| cts_irq_en | input | 1 | Interrupt enable for the change flag |
| cts_chg_clr | input | 1 | Write-one-to-clear for the change flag |
| txd | output | 1 | Serial line output |
| loop_data | output | 1 | Internal loopback bit stream |
| fifo_not_full | output | 1 | Queue can accept a byte |
| overrun | output | 1 | One-cycle pulse after a dropped write |
| cts_chg | output | 1 | Sticky clear-to-send change flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong state or bit count shows up within one character time. It appears as a bad start or stop level, or as a shifted byte, when the line is sampled in the middle of each bit period. Wrong queue pointers show up as bytes out of order, missing or repeated, once the queue drains. Overflow handling shows up at the status outputs one cycle after the write. A fault in the synchronizer or in edge detection shows up in two ways. Either the change flag fails to set within three cycles, or line transitions fall into the high phase of the external clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int CHAR_BITS = 8;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    count_q;
    logic             push_ok, pop_ok;

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_q <= '0;
            ovr     <= 1'b0;
        end else begin
            ovr <= push && full;
            if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count_q == $past(count_q)));  // R4
    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count_q == $past(count_q) + 1'b1));  // R3
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop |-> !empty));  // R12
endmodule

// File: rtl/sertx_modem.sv
module sertx_modem #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic ext_txclk,
    input  logic chg_clr,
    output logic cts_active,
    output logic ext_fall,
    output logic chg
);
    logic [SYNC_STAGES-1:0] cts_sync_q, clk_sync_q;
    logic                   cts_prev_q, clk_prev_q;
    logic                   cts_s, clk_s, cts_edge;

    assign cts_s = cts_sync_q[SYNC_STAGES-1];
    assign clk_s = clk_sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_sync_q <= '1;
            clk_sync_q <= '0;
            cts_prev_q <= 1'b1;
            clk_prev_q <= 1'b0;
        end else begin
            cts_sync_q <= {cts_sync_q[SYNC_STAGES-2:0], cts_n};
            clk_sync_q <= {clk_sync_q[SYNC_STAGES-2:0], ext_txclk};
            cts_prev_q <= cts_s;
            clk_prev_q <= clk_s;
        end
    end

    assign cts_active = !cts_s;
    assign cts_edge   = cts_s ^ cts_prev_q;
    assign ext_fall   = clk_prev_q && !clk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chg <= 1'b0;
        else if (cts_edge) chg <= 1'b1;
        else if (chg_clr)  chg <= 1'b0;
    end

    AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_s != cts_prev_q) |=> chg);  // R9
    AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && !chg_clr) |=> chg);  // R9
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_enable,
    input  logic                 adv,
    input  logic                 gate_en,
    input  logic                 cts_active,
    input  logic                 fifo_empty,
    input  logic [CHAR_BITS-1:0] fifo_head,
    output logic                 fifo_pop,
    output logic                 line
);
    localparam int BCW = $clog2(CHAR_BITS);

    tx_state_e            state_q, state_d;
    logic [CHAR_BITS-1:0] sh_q, sh_d;
    logic [BCW-1:0]       cnt_q, cnt_d;
    logic                 line_q, line_d;
    logic                 can_start;

    assign can_start = !fifo_empty && (!gate_en || cts_active);
    assign line      = line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            line_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        line_d   = line_q;
        fifo_pop = 1'b0;
        if (!tx_enable) begin
            state_d = TX_IDLE;
            line_d  = 1'b1;
        end else if (adv) begin
            unique case (state_q)
                TX_IDLE: begin
                    if (can_start) begin
                        fifo_pop = 1'b1;
                        sh_d     = fifo_head;
                        state_d  = TX_START;
                        line_d   = 1'b0;
                    end
                end
                TX_START: begin
                    line_d  = sh_q[0];
                    sh_d    = sh_q >> 1;
                    cnt_d   = '0;
                    state_d = TX_DATA;
                end
                TX_DATA: begin
                    if (cnt_q == BCW'(CHAR_BITS - 1)) begin
                        line_d  = 1'b1;
                        state_d = TX_STOP;
                    end else begin
                        line_d = sh_q[0];
                        sh_d   = sh_q >> 1;
                        cnt_d  = cnt_q + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (can_start) begin
                        fifo_pop = 1'b1;
                        sh_d     = fifo_head;
                        state_d  = TX_START;
                        line_d   = 1'b0;
                    end else begin
                        state_d = TX_IDLE;
                        line_d  = 1'b1;
                    end
                end
                default: state_d = TX_IDLE;
            endcase
        end
    end

    AST_MARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> (state_q == TX_IDLE && line_q));  // R5
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START) |-> !line_q);  // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STOP) |-> line_q);  // R2
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && gate_en && !cts_active) |=> (state_q == TX_IDLE));  // R7
    AST_FRAME_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && tx_enable) |=> (state_q != TX_IDLE));  // R8
endmodule

// File: rtl/ser_tx_gated.sv
module ser_tx_gated
    import sertx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CHAR_BITS-1:0] wr_data,
    input  logic                 tx_enable,
    input  logic                 loopback,
    input  logic                 ext_clk_sel,
    input  logic                 bit_tick,
    input  logic                 ext_txclk,
    input  logic                 cts_n,
    input  logic                 cts_gate_en,
    input  logic                 cts_irq_en,
    input  logic                 cts_chg_clr,
    output logic                 txd,
    output logic                 loop_data,
    output logic                 fifo_not_full,
    output logic                 overrun,
    output logic                 cts_chg,
    output logic                 irq
);
    logic                 f_empty, f_full, f_pop;
    logic [CHAR_BITS-1:0] f_head;
    logic                 cts_act, ext_fall, adv, line;

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(CHAR_BITS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
        .pop(f_pop), .head(f_head), .empty(f_empty), .full(f_full), .ovr(overrun)
    );

    sertx_modem #(.SYNC_STAGES(SYNC_STAGES)) u_modem (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .ext_txclk(ext_txclk),
        .chg_clr(cts_chg_clr), .cts_active(cts_act), .ext_fall(ext_fall), .chg(cts_chg)
    );

    assign adv = ext_clk_sel ? ext_fall : bit_tick;

    sertx_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .adv(adv),
        .gate_en(cts_gate_en), .cts_active(cts_act), .fifo_empty(f_empty),
        .fifo_head(f_head), .fifo_pop(f_pop), .line(line)
    );

    assign txd           = (tx_enable && !loopback) ? line : 1'b1;
    assign loop_data     = loopback ? line : 1'b1;
    assign fifo_not_full = !f_full;
    assign irq           = cts_chg && cts_irq_en;

    AST_LOOP_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback |-> txd) and (!loopback |-> loop_data));  // R6
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cts_chg && cts_irq_en));  // R10
endmodule

// File: tb/ser_tx_gated_tb.sv
module ser_tx_gated_tb;
    localparam int BITP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic tx_enable = 1'b0, loopback = 1'b0, ext_clk_sel = 1'b0;
    logic bit_tick = 1'b0, ext_txclk = 1'b1, cts_n = 1'b1;
    logic cts_gate_en = 1'b0, cts_irq_en = 1'b0, cts_chg_clr = 1'b0;
    logic txd, loop_data, fifo_not_full, overrun, cts_chg, irq;

    int checks = 0, fails = 0;
    int cnt = 0;
    int ext_bad = 0;
    bit saw_txd_low = 0, saw_loop_low = 0;
    bit done = 0;
    logic prev_txd = 1'b1;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    ser_tx_gated u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_enable(tx_enable), .loopback(loopback), .ext_clk_sel(ext_clk_sel),
        .bit_tick(bit_tick), .ext_txclk(ext_txclk), .cts_n(cts_n),
        .cts_gate_en(cts_gate_en), .cts_irq_en(cts_irq_en), .cts_chg_clr(cts_chg_clr),
        .txd(txd), .loop_data(loop_data), .fifo_not_full(fifo_not_full),
        .overrun(overrun), .cts_chg(cts_chg), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Shift sources and line watchers, all at the falling clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (txd == 1'b0) saw_txd_low = 1;
            if (loop_data == 1'b0) saw_loop_low = 1;
            if (ext_clk_sel && (txd !== prev_txd) && (cnt < 4)) ext_bad++;  // R11
            prev_txd = txd;
            cnt = (cnt + 1) % BITP;
            bit_tick = (cnt == 0);
            ext_txclk = (cnt < 4);
        end
    end

    // Monitor: decode frames on txd and compare against the scoreboard
    initial begin
        forever begin
            logic [7:0] got;
            logic [7:0] exp;
            bit frame_ok;
            @(negedge clk);
            if (rst_n && txd == 1'b0) begin
                frame_ok = 1;
                repeat (BITP / 2 - 1) @(negedge clk);
                if (txd !== 1'b0) frame_ok = 0;
                for (int i = 0; i < 8; i++) begin
                    repeat (BITP) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BITP) @(negedge clk);
                if (txd !== 1'b1) frame_ok = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R12 unexpected frame", got, -1);
                end else begin
                    exp = exp_q.pop_front();
                    check(frame_ok && got == exp, "R2/R12 frame", got, exp);
                end
            end
        end
    end

    task automatic wr_raw(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_q.push_back(d);
        wr_raw(d);
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (3 * BITP) @(negedge clk);
        check(exp_q.size() == 0, "R12 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(txd == 1 && loop_data == 1 && fifo_not_full == 1, "R1 outputs", {txd, loop_data, fifo_not_full}, 7);
        check(overrun == 0 && cts_chg == 0 && irq == 0, "R1 flags", {overrun, cts_chg, irq}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 / R12: basic frames
        tx_enable = 1'b1;
        send(8'hA5); send(8'h01); send(8'h80);
        drain();

        // R3 / R4 / R5: fill while disabled
        tx_enable = 1'b0;
        saw_txd_low = 0;
        for (int i = 0; i < 16; i++) send(8'(i * 17 + 3));
        check(fifo_not_full == 0, "R3 full at 16", fifo_not_full, 0);
        wr_raw(8'hEE);
        check(overrun == 1, "R4 overrun pulse", overrun, 1);
        @(negedge clk);
        check(overrun == 0, "R4 pulse one cycle", overrun, 0);
        repeat (100) @(negedge clk);
        check(saw_txd_low == 0, "R5 mark while disabled", saw_txd_low, 0);
        check(fifo_not_full == 0, "R5 queue retained", fifo_not_full, 0);
        tx_enable = 1'b1;
        drain();
        check(fifo_not_full == 1, "R3 not full after drain", fifo_not_full, 1);

        // R6: loopback
        loopback = 1'b1;
        saw_txd_low = 0;
        saw_loop_low = 0;
        wr_raw(8'h3C);
        repeat (12 * BITP) @(negedge clk);
        check(saw_txd_low == 0, "R6 txd mark in loopback", saw_txd_low, 0);
        check(saw_loop_low == 1, "R6 stream on loop_data", saw_loop_low, 1);
        loopback = 1'b0;
        repeat (2 * BITP) @(negedge clk);

        // R7: gated by deasserted CTS
        cts_gate_en = 1'b1;
        cts_n = 1'b1;
        saw_txd_low = 0;
        send(8'h5A);
        repeat (200) @(negedge clk);
        check(saw_txd_low == 0, "R7 held while CTS high", saw_txd_low, 0);
        check(exp_q.size() == 1, "R7 not sent", exp_q.size(), 1);
        cts_n = 1'b0;
        drain();

        // R8: CTS drops mid-frame
        send(8'hC3);
        while (txd != 1'b0) @(negedge clk);
        repeat (2 * BITP) @(negedge clk);
        cts_n = 1'b1;
        drain();
        cts_gate_en = 1'b0;

        // R9 / R10: change flag
        cts_chg_clr = 1'b1;
        @(negedge clk);
        cts_chg_clr = 1'b0;
        @(negedge clk);
        check(cts_chg == 0, "R9 cleared", cts_chg, 0);
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cts_chg == 1, "R9 falling edge sets", cts_chg, 1);
        check(irq == 0, "R10 masked", irq, 0);
        cts_irq_en = 1'b1;
        #1;
        check(irq == 1, "R10 enabled", irq, 1);
        repeat (5) @(negedge clk);
        check(cts_chg == 1, "R9 sticky", cts_chg, 1);
        cts_chg_clr = 1'b1;
        @(negedge clk);
        cts_chg_clr = 1'b0;
        check(cts_chg == 0 && irq == 0, "R9/R10 clear", {cts_chg, irq}, 0);
        cts_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cts_chg == 1, "R9 rising edge sets", cts_chg, 1);
        cts_irq_en = 1'b0;

        // R11: external clock
        ext_clk_sel = 1'b1;
        ext_bad = 0;
        send(8'h96); send(8'h7E);
        drain();
        check(ext_bad == 0, "R11 change only in low phase", ext_bad, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule